// File: doc/BRIEF.md
# Hidden Configuration Bank Behind a Task-File Port

This block sits on the device side of a legacy IDE task-file port and watches every host byte and word access to the command block. While the bank is closed it lets each access through to the normal drive-register path. A fixed, ordered series of ordinary accesses opens a hidden bank of byte-wide configuration registers. The series is two back-to-back word reads of the error-register offset followed by a byte write of the opening key to the sector-count offset.

While the bank is open, byte writes go to the read-timing, write-timing, control, strap and miscellaneous registers. They do not reach the drive registers. A byte write of the closing key to the sector-count offset shuts the bank again. If the control register holds the override code, the programmed timings replace the strap-selected default timing on the active-timing outputs. After the host arms the strap register, reading that offset returns the board clock-select flag.

Top module: `ide_trapdoor_cfg`

## Requirements
- R1: While reset is high and in the cycle after it, the bank is closed. Both timing registers then hold 0x6B, the slowest setting, the control, strap and miscellaneous registers hold 0x00, and the override is off.
- R2: The bank opens in the cycle after this series: two word reads of offset 1, then a byte write of value 0x03 to offset 2. Cycles with no access inside the series do not disturb it.
- R3: Any other access inside the series sends the detector back to its start, for example a byte read of offset 1 or a word write of 0x03 to offset 2. A third word read of offset 1 still counts as the second of a pair.
- R4: While the bank is closed, the task-file read and write strobes follow the host strobes and read data comes from the task-file path. No configuration register changes.
- R5: While the bank is open, a byte write to offset 0, 1, 3, 5 or 6 loads that register (0 read timing, 1 write timing, 3 control, 5 strap, 6 miscellaneous) in the next cycle. Writes to offsets 2, 4 and 7 and all word writes change nothing, and neither task-file strobe is driven.
- R6: While the bank is open, a byte write of 0x83 to offset 2 closes it in the next cycle and loads no register.
- R7: While the bank is open and the strap register holds 0xFF, a read of offset 5 returns the clock-select input in bit 0 and zero above. With any other strap value it returns that value zero-extended.
- R8: The override output is high exactly when the control register holds 0x85. Then the active timings equal the programmed registers; otherwise both active timings equal the strap default, 0x6B.
- R9: While the bank is open, a read of offset 0, 1, 3 or 6 returns that register zero-extended. A read of offset 2, 4 or 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| io_rd_i | input | 1 | Host read strobe, one cycle per access |
| io_wr_i | input | 1 | Host write strobe, one cycle per access |
| io_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_addr_i | input | 3 | Command-block offset |
| io_wdata_i | input | 16 | Host write data (byte writes use bits 7:0) |
| io_rdata_o | output | 16 | Read data back to the host |
| tf_rdata_i | input | 16 | Read data from the normal task-file registers |
| tf_rd_o | output | 1 | Read strobe passed to the task-file registers |
| tf_wr_o | output | 1 | Write strobe passed to the task-file registers |
| strap_clk_i | input | 1 | Board clock-select strap |
| unlocked_o | output | 1 | Configuration bank is open |
| cfg_rd_tim_o | output | 8 | Programmed read-cycle timing |
| cfg_wr_tim_o | output | 8 | Programmed write-cycle timing |
| cfg_ctrl_o | output | 8 | Control register |
| cfg_strap_o | output | 8 | Strap register |
| cfg_misc_o | output | 8 | Miscellaneous register |
| override_o | output | 1 | Programmed timing overrides the strap default |
| act_rd_tim_o | output | 8 | Read timing in effect |
| act_wr_tim_o | output | 8 | Write timing in effect |

## Verification
The hardest state to reach from the ports is the detector one step short of opening after a broken or stretched series. From there, only the exact key write may open the bank. The stimulus reaches it with ordered access lists: a byte read wedged between the probe reads, a word-sized key, a third probe read in a row, and idle cycles inside the series. The bench checks the open flag after every single access, so an early or missed transition shows up at the access that caused it.

// File: rtl/trap_cfg_pkg.sv
package trap_cfg_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int REG_W  = 8;
    localparam int SLOTS  = 1 << ADDR_W;

    // Offsets that carry a real register inside the hidden bank
    localparam logic [SLOTS-1:0] SLOT_MASK = 8'b0110_1011;

    localparam logic [ADDR_W-1:0] OFF_RD_TIM = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_WR_TIM = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_PROBE  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_KEY    = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_STRAP  = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_MISC   = 3'd6;

    localparam logic [REG_W-1:0] KEY_OPEN      = 8'h03;
    localparam logic [REG_W-1:0] KEY_CLOSE     = 8'h83;
    localparam logic [REG_W-1:0] CTRL_OVERRIDE = 8'h85;
    localparam logic [REG_W-1:0] STRAP_ARM     = 8'hFF;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ONE,
        SEQ_TWO,
        SEQ_OPEN
    } seq_state_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } host_acc_t;

    function automatic logic acc_active(host_acc_t a);
        return a.rd | a.wr;
    endfunction

    function automatic logic is_probe_read(host_acc_t a);
        return a.rd && !a.wr && a.word && (a.addr == OFF_PROBE);
    endfunction

    function automatic logic is_byte_write(host_acc_t a);
        return a.wr && !a.rd && !a.word;
    endfunction

    function automatic logic is_key_write(host_acc_t a, logic [REG_W-1:0] key);
        return is_byte_write(a) && (a.addr == OFF_KEY) &&
               (a.wdata[REG_W-1:0] == key);
    endfunction

endpackage

// File: rtl/trap_seq_detect.sv
module trap_seq_detect
    import trap_cfg_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  host_acc_t acc_i,
    output logic      unlocked_o
);

    seq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (acc_active(acc_i)) begin
            unique case (st_q)
                SEQ_IDLE: st_d = is_probe_read(acc_i) ? SEQ_ONE : SEQ_IDLE;
                SEQ_ONE:  st_d = is_probe_read(acc_i) ? SEQ_TWO : SEQ_IDLE;
                SEQ_TWO: begin
                    if (is_key_write(acc_i, KEY_OPEN))
                        st_d = SEQ_OPEN;
                    else if (is_probe_read(acc_i))
                        st_d = SEQ_TWO;   // last two accesses still form a pair
                    else
                        st_d = SEQ_IDLE;
                end
                SEQ_OPEN: st_d = is_key_write(acc_i, KEY_CLOSE) ? SEQ_IDLE : SEQ_OPEN;
                default:  st_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= SEQ_IDLE;
        else       st_q <= st_d;
    end

    assign unlocked_o = (st_q == SEQ_OPEN);

endmodule

// File: rtl/trap_cfg_bank.sv
module trap_cfg_bank
    import trap_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_TIMING = 8'h6B
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  host_acc_t        acc_i,
    input  logic             unlocked_i,
    output logic [REG_W-1:0] slot_o [SLOTS]
);

    logic bank_wr;
    assign bank_wr = unlocked_i && is_byte_write(acc_i);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(g);
        if (SLOT_MASK[g]) begin : g_impl
            localparam logic [REG_W-1:0] RST_V =
                ((SLOT_ADDR == OFF_RD_TIM) || (SLOT_ADDR == OFF_WR_TIM)) ? RESET_TIMING : '0;
            logic [REG_W-1:0] q;
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    q <= RST_V;
                else if (bank_wr && (acc_i.addr == SLOT_ADDR))
                    q <= acc_i.wdata[REG_W-1:0];
            end
            assign slot_o[g] = q;
        end else begin : g_hole
            assign slot_o[g] = '0;
        end
    end

endmodule

// File: rtl/trap_read_path.sv
module trap_read_path
    import trap_cfg_pkg::*;
(
    input  logic              unlocked_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  slot_i [SLOTS],
    input  logic              strap_clk_i,
    input  logic [DATA_W-1:0] tf_rdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic strap_armed;
    assign strap_armed = (slot_i[OFF_STRAP] == STRAP_ARM);

    always_comb begin
        if (!unlocked_i)
            rdata_o = tf_rdata_i;
        else if ((addr_i == OFF_STRAP) && strap_armed)
            rdata_o = {{(DATA_W-1){1'b0}}, strap_clk_i};
        else
            rdata_o = {{(DATA_W-REG_W){1'b0}}, slot_i[addr_i]};
    end

endmodule

// File: rtl/ide_trapdoor_cfg.sv
module ide_trapdoor_cfg
    import trap_cfg_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_TIMING = 8'h6B,
    parameter logic [REG_W-1:0] STRAP_TIMING = 8'h6B
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    input  logic              io_word_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic [DATA_W-1:0] io_wdata_i,
    output logic [DATA_W-1:0] io_rdata_o,
    input  logic [DATA_W-1:0] tf_rdata_i,
    output logic              tf_rd_o,
    output logic              tf_wr_o,
    input  logic              strap_clk_i,
    output logic              unlocked_o,
    output logic [REG_W-1:0]  cfg_rd_tim_o,
    output logic [REG_W-1:0]  cfg_wr_tim_o,
    output logic [REG_W-1:0]  cfg_ctrl_o,
    output logic [REG_W-1:0]  cfg_strap_o,
    output logic [REG_W-1:0]  cfg_misc_o,
    output logic              override_o,
    output logic [REG_W-1:0]  act_rd_tim_o,
    output logic [REG_W-1:0]  act_wr_tim_o
);

    host_acc_t        acc;
    logic             open_q;
    logic [REG_W-1:0] slots [SLOTS];

    assign acc = '{rd: io_rd_i, wr: io_wr_i, word: io_word_i,
                   addr: io_addr_i, wdata: io_wdata_i};

    trap_seq_detect u_detect (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .acc_i      (acc),
        .unlocked_o (open_q)
    );

    trap_cfg_bank #(
        .RESET_TIMING (RESET_TIMING)
    ) u_bank (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .acc_i      (acc),
        .unlocked_i (open_q),
        .slot_o     (slots)
    );

    trap_read_path u_rd (
        .unlocked_i  (open_q),
        .addr_i      (io_addr_i),
        .slot_i      (slots),
        .strap_clk_i (strap_clk_i),
        .tf_rdata_i  (tf_rdata_i),
        .rdata_o     (io_rdata_o)
    );

    // Host strobes reach the drive registers only while the bank is shut
    assign tf_rd_o = io_rd_i && !open_q;
    assign tf_wr_o = io_wr_i && !open_q;

    assign unlocked_o   = open_q;
    assign cfg_rd_tim_o = slots[OFF_RD_TIM];
    assign cfg_wr_tim_o = slots[OFF_WR_TIM];
    assign cfg_ctrl_o   = slots[OFF_CTRL];
    assign cfg_strap_o  = slots[OFF_STRAP];
    assign cfg_misc_o   = slots[OFF_MISC];

    assign override_o   = (slots[OFF_CTRL] == CTRL_OVERRIDE);
    assign act_rd_tim_o = override_o ? slots[OFF_RD_TIM] : STRAP_TIMING;
    assign act_wr_tim_o = override_o ? slots[OFF_WR_TIM] : STRAP_TIMING;

endmodule

// File: rtl/trap_cfg_checker.sv
module trap_cfg_checker
    import trap_cfg_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              io_rd_i,
    input logic              io_wr_i,
    input logic              io_word_i,
    input logic [ADDR_W-1:0] io_addr_i,
    input logic [REG_W-1:0]  io_wdata_lo,
    input logic [DATA_W-1:0] io_rdata_o,
    input logic [DATA_W-1:0] tf_rdata_i,
    input logic              tf_rd_o,
    input logic              tf_wr_o,
    input logic              strap_clk_i,
    input logic              unlocked_o,
    input logic [REG_W-1:0]  cfg_rd_tim_o,
    input logic [REG_W-1:0]  cfg_wr_tim_o,
    input logic [REG_W-1:0]  cfg_ctrl_o,
    input logic [REG_W-1:0]  cfg_strap_o,
    input logic [REG_W-1:0]  cfg_misc_o,
    input logic              override_o,
    input logic [REG_W-1:0]  act_rd_tim_o,
    input logic [REG_W-1:0]  act_wr_tim_o
);

    AST_RESET_LOCKS: assert property (@(posedge clk_i)
        rst_i |=> !unlocked_o && !override_o); // R1

    AST_LOCKED_PASSTHRU: assert property (@(posedge clk_i) disable iff (rst_i)
        !unlocked_o |-> (tf_rd_o == io_rd_i) && (tf_wr_o == io_wr_i) &&
                        (io_rdata_o == tf_rdata_i)); // R4

    AST_LOCKED_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !unlocked_o |=> $stable(cfg_rd_tim_o) && $stable(cfg_wr_tim_o) &&
                        $stable(cfg_ctrl_o) && $stable(cfg_strap_o) &&
                        $stable(cfg_misc_o)); // R4

    AST_OPEN_NO_PASS: assert property (@(posedge clk_i) disable iff (rst_i)
        unlocked_o |-> !tf_rd_o && !tf_wr_o); // R5

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(unlocked_o) |-> $past(io_wr_i && !io_word_i && (io_addr_i == OFF_KEY) &&
                                    (io_wdata_lo == KEY_OPEN))); // R2

    AST_RELOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        unlocked_o && io_wr_i && !io_rd_i && !io_word_i && (io_addr_i == OFF_KEY) &&
        (io_wdata_lo == KEY_CLOSE) |=> !unlocked_o); // R6

    AST_OVERRIDE_APPLIES: assert property (@(posedge clk_i) disable iff (rst_i)
        override_o |-> (act_rd_tim_o == cfg_rd_tim_o) && (act_wr_tim_o == cfg_wr_tim_o)); // R8

    AST_STRAP_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        unlocked_o && (io_addr_i == OFF_STRAP) && (cfg_strap_o == STRAP_ARM) |->
        io_rdata_o == {{(DATA_W-1){1'b0}}, strap_clk_i}); // R7

endmodule

bind ide_trapdoor_cfg trap_cfg_checker chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .io_rd_i      (io_rd_i),
    .io_wr_i      (io_wr_i),
    .io_word_i    (io_word_i),
    .io_addr_i    (io_addr_i),
    .io_wdata_lo  (io_wdata_i[7:0]),
    .io_rdata_o   (io_rdata_o),
    .tf_rdata_i   (tf_rdata_i),
    .tf_rd_o      (tf_rd_o),
    .tf_wr_o      (tf_wr_o),
    .strap_clk_i  (strap_clk_i),
    .unlocked_o   (unlocked_o),
    .cfg_rd_tim_o (cfg_rd_tim_o),
    .cfg_wr_tim_o (cfg_wr_tim_o),
    .cfg_ctrl_o   (cfg_ctrl_o),
    .cfg_strap_o  (cfg_strap_o),
    .cfg_misc_o   (cfg_misc_o),
    .override_o   (override_o),
    .act_rd_tim_o (act_rd_tim_o),
    .act_wr_tim_o (act_wr_tim_o)
);

// File: tb/ide_trapdoor_cfg_tb.sv
module ide_trapdoor_cfg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] TF_DATA = 16'hA5C3;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        word;
        logic [2:0]  addr;
        logic [15:0] wdata;
        logic        exp_unl;
        logic        chk_rd;
        logic [15:0] exp_rdata;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,1'b0,1'b1,16'hA5C3,4'd4}, // R4 probe read passes through
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,1'b0,1'b0,16'h0000,4'd2}, // R2 second probe
        '{1'b0,1'b1,1'b0,3'd2,16'h0003,1'b1,1'b0,16'h0000,4'd2}, // R2 key opens
        '{1'b0,1'b1,1'b0,3'd0,16'h0042,1'b1,1'b0,16'h0000,4'd5}, // R5 read timing
        '{1'b1,1'b0,1'b0,3'd0,16'h0000,1'b1,1'b1,16'h0042,4'd9}, // R9 readback
        '{1'b0,1'b1,1'b0,3'd1,16'h0031,1'b1,1'b0,16'h0000,4'd5}, // R5 write timing
        '{1'b0,1'b1,1'b0,3'd5,16'h00FF,1'b1,1'b0,16'h0000,4'd5}, // R5 arm strap
        '{1'b1,1'b0,1'b1,3'd5,16'h0000,1'b1,1'b1,16'h0001,4'd7}, // R7 clock flag
        '{1'b0,1'b1,1'b0,3'd6,16'h0010,1'b1,1'b0,16'h0000,4'd5}, // R5 misc
        '{1'b0,1'b1,1'b1,3'd3,16'h0085,1'b1,1'b0,16'h0000,4'd5}, // R5 word write ignored
        '{1'b1,1'b0,1'b0,3'd3,16'h0000,1'b1,1'b1,16'h0000,4'd5}, // R5 control unchanged
        '{1'b0,1'b1,1'b0,3'd4,16'h0077,1'b1,1'b0,16'h0000,4'd5}, // R5 hole offset
        '{1'b1,1'b0,1'b0,3'd4,16'h0000,1'b1,1'b1,16'h0000,4'd9}, // R9 hole reads zero
        '{1'b0,1'b1,1'b0,3'd2,16'h0083,1'b0,1'b0,16'h0000,4'd6}, // R6 close
        '{1'b1,1'b0,1'b0,3'd0,16'h0000,1'b0,1'b1,16'hA5C3,4'd4}, // R4 pass through again
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,1'b0,1'b0,16'h0000,4'd3}, // R3 probe
        '{1'b1,1'b0,1'b0,3'd1,16'h0000,1'b0,1'b0,16'h0000,4'd3}, // R3 byte read breaks
        '{1'b0,1'b1,1'b0,3'd2,16'h0003,1'b0,1'b0,16'h0000,4'd3}, // R3 key too early
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,1'b0,1'b0,16'h0000,4'd3}, // R3 probe
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,1'b0,1'b0,16'h0000,4'd3}, // R3 probe
        '{1'b1,1'b0,1'b1,3'd1,16'h0000,1'b0,1'b0,16'h0000,4'd3}, // R3 third probe
        '{1'b0,1'b1,1'b0,3'd2,16'h0003,1'b1,1'b0,16'h0000,4'd3}, // R3 key opens
        '{1'b0,1'b1,1'b0,3'd3,16'h0085,1'b1,1'b0,16'h0000,4'd8}, // R8 override code
        '{1'b0,1'b1,1'b0,3'd2,16'h0083,1'b0,1'b0,16'h0000,4'd6}  // R6 close
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_rd = 1'b0, io_wr = 1'b0, io_word = 1'b0;
    logic [2:0]  io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic [15:0] tf_rdata = TF_DATA;
    logic        tf_rd, tf_wr;
    logic        strap_clk = 1'b1;
    logic        unlocked, override_s;
    logic [7:0]  rd_tim, wr_tim, ctrl, strap, misc, act_rd, act_wr;

    logic [15:0] cap_rdata;
    logic        cap_tfrd, cap_tfwr;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_trapdoor_cfg dut_i (
        .clk_i (clk), .rst_i (rst),
        .io_rd_i (io_rd), .io_wr_i (io_wr), .io_word_i (io_word),
        .io_addr_i (io_addr), .io_wdata_i (io_wdata), .io_rdata_o (io_rdata),
        .tf_rdata_i (tf_rdata), .tf_rd_o (tf_rd), .tf_wr_o (tf_wr),
        .strap_clk_i (strap_clk), .unlocked_o (unlocked),
        .cfg_rd_tim_o (rd_tim), .cfg_wr_tim_o (wr_tim), .cfg_ctrl_o (ctrl),
        .cfg_strap_o (strap), .cfg_misc_o (misc), .override_o (override_s),
        .act_rd_tim_o (act_rd), .act_wr_tim_o (act_wr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host access; captures combinational outputs mid-cycle, returns after the edge
    task automatic access(input logic rd, input logic wr, input logic word,
                          input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_word = word; io_addr = a; io_wdata = d;
        #1;
        cap_rdata = io_rdata; cap_tfrd = tf_rd; cap_tfwr = tf_wr;
        @(posedge clk);
        #1;
        io_rd = 1'b0; io_wr = 1'b0; io_word = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic open_bank();
        access(1, 0, 1, 3'd1, 16'h0);
        access(1, 0, 1, 3'd1, 16'h0);
        access(0, 1, 0, 3'd2, 16'h0003);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic prev_unl;
        idle(3);
        // R1 reset state
        check("R1 unlocked", {15'b0, unlocked}, 16'h0);
        check("R1 rd_tim", {8'h0, rd_tim}, 16'h006B);
        check("R1 wr_tim", {8'h0, wr_tim}, 16'h006B);
        check("R1 ctrl", {8'h0, ctrl}, 16'h0);
        check("R1 override", {15'b0, override_s}, 16'h0);
        @(negedge clk);
        rst = 1'b0;
        idle(1);

        prev_unl = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            access(VECS[i].rd, VECS[i].wr, VECS[i].word, VECS[i].addr, VECS[i].wdata);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check({tag, " unlocked"}, {15'b0, unlocked}, {15'b0, VECS[i].exp_unl});
            if (VECS[i].chk_rd)
                check({tag, " rdata"}, cap_rdata, VECS[i].exp_rdata);
            check($sformatf("R%0d vec%0d tf strobes", prev_unl ? 5 : 4, i),
                  {14'b0, cap_tfrd, cap_tfwr},
                  {14'b0, VECS[i].rd && !prev_unl, VECS[i].wr && !prev_unl});
            prev_unl = VECS[i].exp_unl;
        end

        // R8 override in force with programmed timings
        check("R8 override", {15'b0, override_s}, 16'h1);
        check("R8 act_rd", {8'h0, act_rd}, 16'h0042);
        check("R8 act_wr", {8'h0, act_wr}, 16'h0031);
        check("R5 misc", {8'h0, misc}, 16'h0010);

        // R4 closed-bank write leaves registers alone
        access(0, 1, 0, 3'd0, 16'h0099);
        check("R4 tf_wr", {15'b0, cap_tfwr}, 16'h1);
        check("R4 rd_tim frozen", {8'h0, rd_tim}, 16'h0042);

        // R7 flag low, then non-armed strap
        strap_clk = 1'b0;
        open_bank();
        access(1, 0, 1, 3'd5, 16'h0);
        check("R7 flag low", cap_rdata, 16'h0000);
        access(0, 1, 0, 3'd5, 16'h0012);
        access(1, 0, 1, 3'd5, 16'h0);
        check("R7 plain strap", cap_rdata, 16'h0012);
        // R8 override off returns default timing
        access(0, 1, 0, 3'd3, 16'h0000);
        check("R8 override off", {15'b0, override_s}, 16'h0);
        check("R8 act_rd default", {8'h0, act_rd}, 16'h006B);
        access(0, 1, 0, 3'd2, 16'h0083);
        check("R6 closed", {15'b0, unlocked}, 16'h0);

        // R2 idle cycles inside the series
        access(1, 0, 1, 3'd1, 16'h0);
        idle(3);
        access(1, 0, 1, 3'd1, 16'h0);
        idle(2);
        access(0, 1, 0, 3'd2, 16'h0003);
        check("R2 with gaps", {15'b0, unlocked}, 16'h1);
        access(0, 1, 0, 3'd2, 16'h0083);

        // R3 word-sized key does not open
        access(1, 0, 1, 3'd1, 16'h0);
        access(1, 0, 1, 3'd1, 16'h0);
        access(0, 1, 1, 3'd2, 16'h0003);
        check("R3 word key", {15'b0, unlocked}, 16'h0);

        // R1 reset while open
        open_bank();
        access(0, 1, 0, 3'd6, 16'h005A);
        check("R1 pre-reset open", {15'b0, unlocked}, 16'h1);
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 relocked", {15'b0, unlocked}, 16'h0);
        check("R1 misc cleared", {8'h0, misc}, 16'h0);
        check("R1 rd_tim slow", {8'h0, rd_tim}, 16'h006B);

        done = 1;
        summary();
        $finish;
    end

endmodule